// File: doc/BRIEF.md
# Audio Port Register File

This block is the control and configuration register bank of an audio serial-port controller. A host reaches it over a plain synchronous 16-bit bus. The bus has a word address, a write strobe with write data, and a read strobe. Read data and an access-error flag come back registered, one cycle after the strobe. The bank holds the port setup bytes, a small test interface (control, address and a byte-split data word), volume-threshold bytes, control and config words for two auxiliary links, the mixer and gain words, attenuation, three general audio config words, a control word and a system config word. Two registers are constant identifiers.

Each register keeps only the bits its write mask allows. Writing the system config word with bit 1 set returns every register to its default. The system config word itself then holds the written value after masking, so the reset bit never reads back as set. Some reads are built on the fly: two live status inputs appear in the test control word, the volume-high byte always reports both converters ready, and the control word mirrors its enable bit into bit 15.

The block also drives the effective sample rate continuously. It is taken from one of three config fields under a fixed priority and given as an index into a table of eight rates, together with a valid flag and the level that supplied it.

Top module: `apr_regfile`

## Requirements
- R1: Word offsets and reset values, after reset: 0..3 port setup bytes 0x000C, 0x0009, 0x00AB, 0x0003; 4 test control; 5 test address; 6 test data low byte; 7 test data high byte; 8 volume-low; 9 volume-high; 10/11 link A control/config; 12/13 link B control/config; 14 mixer; 15 master gain 0xE7E7; 16..18 channel gains 0x6767; 19 attenuation 0x00CE; 20 general config 0x0649; 21 control 0x0000; 22 config2 0x0007; 23 config3 0x1FFC; 24 version; 25 system config; 26 system status. Every register not named with a value resets to 0.
- R2: A write to offset k stores the write data ANDed with that register's mask: setup bytes, test address, data bytes and attenuation 0x00FF; test control 0x005F; volume-low 0x00F8; volume-high 0x009F; both link controls 0x008F; both link configs 0x7FFF; mixer 0x0FFF; master gain and config3 0xFFFF; channel gains 0xFF7F; general config 0x07FF; control 0x780F; config2 0x003F.
- R3: Writing offset 25 with data bit 1 set returns every register to its R1 value in the next cycle. Offset 25 then holds the data ANDed with 0x031D, so its bit 1 reads 0. Without bit 1 set, offset 25 just stores the masked data.
- R4: Offset 24 reads 0x0010 and offset 26 reads 0x000F. A write to either leaves the value unchanged and raises the error flag in the following cycle.
- R5: The test data word is split in two bytes: offset 6 holds bits 7:0 and offset 7 holds bits 15:8. Each is written and read on its own, and a write to one leaves the other unchanged.
- R6: A read of offset 9 returns the stored byte with bits 6:5 forced to 1.
- R7: A read of offset 21 returns the stored value with bit 1 copied into bit 15.
- R8: A read of offset 4 returns the stored value, plus bit 7 = rx_avail_i and bit 5 = tx_room_i sampled in the read cycle.
- R9: A read or write at any offset above 26 raises the error flag for exactly the one following cycle. The read returns 0 and no register changes. Mapped reads and writes to writable offsets leave the flag at 0.
- R10: The rate index encodes 0:8000, 1:11025, 2:16000, 3:22050, 4:24000, 5:32000, 6:44100, 7:48000 Hz. When config3 bits 12:9 are not 15, they select the rate directly: level 2, and codes 0..7 are valid with index equal to the code.
- R11: Otherwise, when config2 bits 2:0 are not 7, they give level 1 with codes 0..4 mapping to 8000, 11025, 22050, 44100, 48000. Otherwise general config bits 7:6 give level 0 with codes 0..3 mapping to 8000, 11025, 22050, 44100.
- R12: A code that maps to no rate gives rate_ok_o = 0 and rate_idx_o = 15. The rate outputs follow a config write from the next cycle.
- R13: Read data appears on rdata_o in the cycle after rd_en_i and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Word offset of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| err_o | output | 1 | One-cycle pulse for a rejected or unmapped access |
| rx_avail_i | input | 1 | Live status: receive samples pending |
| tx_room_i | input | 1 | Live status: transmit space free |
| rate_idx_o | output | 4 | Decoded sample-rate index, 15 when invalid |
| rate_ok_o | output | 1 | Decoded rate is valid |
| rate_lvl_o | output | 2 | Field that supplied the rate: 2 config3, 1 config2, 0 general config |

## Verification
The bench sweeps the entire address space both at reset and after a soft reset. A design that dropped a default, left the system config bit 1 set, or let a soft reset skip a register shows up there as a mismatched word. Every writable offset receives all-ones, all-zeros, checkerboards and a walking bit. This exposes a mask that is off by a bit and a write that decodes to the wrong register, including a disturbed neighbouring byte of the test data word. The constant registers and unmapped offsets are written and read to catch a write that lands, a missing error pulse, or non-zero data on an unmapped read. All 512 combinations of the three rate fields are applied, which catches a priority inverted between levels, the shorter tables indexed with the long table, and an invalid code reported as valid.

// File: rtl/apr_pkg.sv
// Package: register offsets, reset values, write masks and the rate record
// shared by the audio port register file and its submodules.
// Assumes 16-bit registers and word addressing.
package apr_pkg;
    localparam int DW   = 16;
    localparam int NREG = 27;

    localparam int RA_PCFG0   = 0;
    localparam int RA_PCFG3   = 3;
    localparam int RA_TCTL    = 4;
    localparam int RA_TADDR   = 5;
    localparam int RA_TDATL   = 6;
    localparam int RA_TDATH   = 7;
    localparam int RA_VLOW    = 8;
    localparam int RA_VHIGH   = 9;
    localparam int RA_LACTL   = 10;
    localparam int RA_LACFG   = 11;
    localparam int RA_LBCTL   = 12;
    localparam int RA_LBCFG   = 13;
    localparam int RA_MIX     = 14;
    localparam int RA_GAIN0   = 15;
    localparam int RA_GAIN3   = 18;
    localparam int RA_ATT     = 19;
    localparam int RA_GCFG    = 20;
    localparam int RA_GCTL    = 21;
    localparam int RA_GCFG2   = 22;
    localparam int RA_GCFG3   = 23;
    localparam int RA_VERSION = 24;
    localparam int RA_SYSCFG  = 25;
    localparam int RA_SYSSTAT = 26;

    localparam int SOFT_RST_BIT = 1;
    localparam int RATE_IDX_W   = 4;
    localparam logic [RATE_IDX_W-1:0] RATE_NONE = '1;

    // Decoded sample-rate record.
    typedef struct packed {
        logic [RATE_IDX_W-1:0] idx;
        logic                  ok;
        logic [1:0]            lvl;
    } rate_t;

    // Reset value of register i.
    function automatic logic [DW-1:0] reg_default(int i);
        case (i)
            0:        return 16'h000C;
            1:        return 16'h0009;
            2:        return 16'h00AB;
            3:        return 16'h0003;
            15:       return 16'hE7E7;
            16,17,18: return 16'h6767;
            19:       return 16'h00CE;
            20:       return 16'h0649;
            22:       return 16'h0007;
            23:       return 16'h1FFC;
            24:       return 16'h0010;
            26:       return 16'h000F;
            default:  return 16'h0000;
        endcase
    endfunction

    // Bits of register i that a write may change; zero for constant registers.
    function automatic logic [DW-1:0] reg_mask(int i);
        case (i)
            0,1,2,3,5,6,7,19: return 16'h00FF;
            4:                return 16'h005F;
            8:                return 16'h00F8;
            9:                return 16'h009F;
            10,12:            return 16'h008F;
            11,13:            return 16'h7FFF;
            14:               return 16'h0FFF;
            15,23:            return 16'hFFFF;
            16,17,18:         return 16'hFF7F;
            20:               return 16'h07FF;
            21:               return 16'h780F;
            22:               return 16'h003F;
            25:               return 16'h031D;
            default:          return 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/apr_decode.sv
// Address decoder: one select per mapped register, plus a hit and a
// read-only flag. Assumes ADDR_W is wide enough to reach every register.
module apr_decode
    import apr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NREG-1:0]   sel_o,
    output logic              hit_o,
    output logic              ro_o
);
    // One comparator per register offset.
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel_o[i] = (addr_i == ADDR_W'(i));
    end

    // Mapped flag and constant-register flag.
    assign hit_o = |sel_o;
    assign ro_o  = sel_o[RA_VERSION] | sel_o[RA_SYSSTAT];
endmodule

// File: rtl/apr_store.sv
// Register storage: one masked register per offset, with per-register reset
// values, a write strobe and a software reset that keeps the masked write
// data in the system config register. Constant registers have a zero mask.
module apr_store
    import apr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb_i,
    input  logic                     soft_rst_i,
    input  logic [NREG-1:0]          sel_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [NREG-1:0][DW-1:0]  regs_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] DEF    = reg_default(i);
        localparam logic [DW-1:0] MSK    = reg_mask(i);
        localparam bit            IS_SYS = (i == RA_SYSCFG);
        logic [DW-1:0] q;

        // Hold, reset, soft-reset or masked-write one register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= DEF;
            else if (soft_rst_i)
                q <= IS_SYS ? (wdata_i & MSK) : DEF;
            else if (wr_stb_i && sel_i[i])
                q <= wdata_i & MSK;
        end

        assign regs_o[i] = q;
    end

    AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (regs_o[RA_GAIN0] == 16'hE7E7) && (regs_o[RA_GCFG3] == 16'h1FFC)
                       && (regs_o[RA_SYSCFG][SOFT_RST_BIT] == 1'b0)); // R3
    AST_CONST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i || soft_rst_i) |=> (regs_o[RA_VERSION] == 16'h0010)
                                     && (regs_o[RA_SYSSTAT] == 16'h000F)); // R4
endmodule

// File: rtl/apr_rate.sv
// Sample-rate decoder: a three-level priority choice between the config3
// code, the config2 code and the general-config code, each mapped onto a
// common index of eight rates. Purely combinational.
module apr_rate
    import apr_pkg::*;
(
    input  logic [3:0] code3_i,
    input  logic [2:0] code2_i,
    input  logic [1:0] code0_i,
    output rate_t      rate_o
);
    // Priority select and per-level mapping onto the common index.
    always_comb begin
        rate_o = '{idx: RATE_NONE, ok: 1'b0, lvl: 2'd0};
        if (code3_i != 4'hF) begin
            rate_o.lvl = 2'd2;
            if (code3_i < 4'd8) begin
                rate_o.idx = code3_i;
                rate_o.ok  = 1'b1;
            end
        end else if (code2_i != 3'd7) begin
            rate_o.lvl = 2'd1;
            rate_o.ok  = 1'b1;
            case (code2_i)
                3'd0:    rate_o.idx = 4'd0;
                3'd1:    rate_o.idx = 4'd1;
                3'd2:    rate_o.idx = 4'd3;
                3'd3:    rate_o.idx = 4'd6;
                3'd4:    rate_o.idx = 4'd7;
                default: begin
                    rate_o.idx = RATE_NONE;
                    rate_o.ok  = 1'b0;
                end
            endcase
        end else begin
            rate_o.lvl = 2'd0;
            rate_o.ok  = 1'b1;
            case (code0_i)
                2'd0:    rate_o.idx = 4'd0;
                2'd1:    rate_o.idx = 4'd1;
                2'd2:    rate_o.idx = 4'd3;
                default: rate_o.idx = 4'd6;
            endcase
        end
    end
endmodule

// File: rtl/apr_regfile.sv
// Audio port register file, top level. Decodes the bus access, writes the
// register store, composes read data from stored and live values, and flags
// writes to constant or unmapped offsets and reads of unmapped offsets.
// Read data and error are registered one cycle after the strobe.
module apr_regfile
    import apr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [15:0]       wdata_i,
    input  logic              rd_en_i,
    output logic [15:0]       rdata_o,
    output logic              err_o,
    input  logic              rx_avail_i,
    input  logic              tx_room_i,
    output logic [3:0]        rate_idx_o,
    output logic              rate_ok_o,
    output logic [1:0]        rate_lvl_o
);
    logic [NREG-1:0]         sel;
    logic                    hit;
    logic                    ro;
    logic                    wr_stb;
    logic                    soft_rst;
    logic [NREG-1:0][DW-1:0] regs;
    logic [DW-1:0]           rd_val;
    rate_t                   rate;

    apr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (addr_i),
        .sel_o  (sel),
        .hit_o  (hit),
        .ro_o   (ro)
    );

    // Accepted write and software-reset request.
    assign wr_stb   = wr_en_i && hit && !ro;
    assign soft_rst = wr_en_i && sel[RA_SYSCFG] && wdata_i[SOFT_RST_BIT];

    apr_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb_i   (wr_stb),
        .soft_rst_i (soft_rst),
        .sel_i      (sel),
        .wdata_i    (wdata_i),
        .regs_o     (regs)
    );

    apr_rate u_rate (
        .code3_i (regs[RA_GCFG3][12:9]),
        .code2_i (regs[RA_GCFG2][2:0]),
        .code0_i (regs[RA_GCFG][7:6]),
        .rate_o  (rate)
    );

    assign rate_idx_o = rate.idx;
    assign rate_ok_o  = rate.ok;
    assign rate_lvl_o = rate.lvl;

    // Read value: selected register with live and forced fields merged in.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++)
            if (sel[i]) rd_val = regs[i];
        if (sel[RA_TCTL])
            rd_val = rd_val | {8'h00, rx_avail_i, 1'b0, tx_room_i, 5'b00000};
        if (sel[RA_VHIGH])
            rd_val = rd_val | 16'h0060;
        if (sel[RA_GCTL])
            rd_val = {rd_val[1], rd_val[14:0]};
    end

    // Registered read data, updated only on reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_en_i)
            rdata_o <= rd_val;
    end

    // One-cycle error pulse for rejected or unmapped accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else
            err_o <= (wr_en_i && (!hit || ro)) || (rd_en_i && !hit);
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R9
    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en_i || rd_en_i) && !hit) |=> err_o); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit) |=> (rdata_o == 16'h0000)); // R9
    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i || rd_en_i) |=> !err_o); // R9
    AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ro) |=> err_o); // R4
    AST_VHIGH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel[RA_VHIGH]) |=> (rdata_o[6:5] == 2'b11)); // R6
    AST_GCTL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel[RA_GCTL]) |=> (rdata_o[15] == rdata_o[1])); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)); // R13
    AST_RATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rate_ok_o |-> (rate_idx_o < 4'd8)); // R10
    AST_RATE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_ok_o |-> (rate_idx_o == 4'hF)); // R12
endmodule

// File: tb/tb_apr_regfile.sv
// Self-checking bench: address sweeps, mask sweeps, soft reset, live status
// and an exhaustive sweep of the three rate fields against an arithmetic model.
module tb_apr_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        err;
    logic        rx_avail = 1'b0;
    logic        tx_room = 1'b0;
    logic [3:0]  rate_idx;
    logic        rate_ok;
    logic [1:0]  rate_lvl;

    int nvec = 0;
    int nfail = 0;
    bit reported = 1'b0;
    logic [15:0] model [27];

    always #2 clk = ~clk;

    apr_regfile #(.ADDR_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .err_o(err),
        .rx_avail_i(rx_avail), .tx_room_i(tx_room),
        .rate_idx_o(rate_idx), .rate_ok_o(rate_ok), .rate_lvl_o(rate_lvl)
    );

    function automatic logic [15:0] b_def(int a);
        case (a)
            0: return 16'h000C;  1: return 16'h0009;  2: return 16'h00AB;
            3: return 16'h0003;  15: return 16'hE7E7; 16: return 16'h6767;
            17: return 16'h6767; 18: return 16'h6767; 19: return 16'h00CE;
            20: return 16'h0649; 22: return 16'h0007; 23: return 16'h1FFC;
            24: return 16'h0010; 26: return 16'h000F;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] b_mask(int a);
        if (a <= 3 || a == 5 || a == 6 || a == 7 || a == 19) return 16'h00FF;
        case (a)
            4: return 16'h005F;  8: return 16'h00F8;  9: return 16'h009F;
            10: return 16'h008F; 12: return 16'h008F; 11: return 16'h7FFF;
            13: return 16'h7FFF; 14: return 16'h0FFF; 15: return 16'hFFFF;
            23: return 16'hFFFF; 16: return 16'hFF7F; 17: return 16'hFF7F;
            18: return 16'hFF7F; 20: return 16'h07FF; 21: return 16'h780F;
            22: return 16'h003F; 25: return 16'h031D;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] b_read(int a);
        logic [15:0] v;
        if (a > 26) return 16'h0000;
        v = model[a];
        if (a == 4) v = v | (16'(rx_avail) << 7) | (16'(tx_room) << 5);
        if (a == 9) v = v | 16'h0060;
        if (a == 21) v = {v[1], v[14:0]};
        return v;
    endfunction

    function automatic string req_of(int a);
        if (a == 4) return "R8";
        if (a == 6 || a == 7) return "R5";
        if (a == 9) return "R6";
        if (a == 21) return "R7";
        if (a == 24 || a == 26) return "R4";
        if (a > 26) return "R9";
        return "R2";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 27; i++) model[i] = b_def(i);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    // Bus write; checks the error pulse and updates the model.
    task automatic bus_wr(input int a, input logic [15:0] d);
        logic exp_err;
        exp_err = (a > 26) || (a == 24) || (a == 26);
        @(negedge clk);
        addr = 6'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(exp_err ? ((a > 26) ? "R9" : "R4") : "R9", 16'(err), 16'(exp_err));
        if (a == 25 && d[1]) begin
            model_reset();
            model[25] = d & 16'h031D;
        end else if (!exp_err) begin
            model[a] = d & b_mask(a);
        end
    endtask

    // Bus read; checks data one cycle later and the error flag.
    task automatic bus_rd(input int a, input string req);
        logic [15:0] exp;
        @(negedge clk);
        addr = 6'(a); rd_en = 1'b1;
        exp = b_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp);
        check("R9", 16'(err), 16'(a > 26));
    endtask

    task automatic sweep_all(input string req);
        for (int a = 0; a < 64; a++) bus_rd(a, req);
    endtask

    // Arithmetic rate model.
    function automatic int hz3(int c);
        case (c)
            0: return 8000; 1: return 11025; 2: return 16000; 3: return 22050;
            4: return 24000; 5: return 32000; 6: return 44100; 7: return 48000;
            default: return 0;
        endcase
    endfunction
    function automatic int hz2(int c);
        case (c)
            0: return 8000; 1: return 11025; 2: return 22050; 3: return 44100;
            4: return 48000; default: return 0;
        endcase
    endfunction
    function automatic int hz0(int c);
        case (c)
            0: return 8000; 1: return 11025; 2: return 22050; default: return 44100;
        endcase
    endfunction
    function automatic int idx_of(int hz);
        int tbl [8] = '{8000, 11025, 16000, 22050, 24000, 32000, 44100, 48000};
        for (int k = 0; k < 8; k++) if (tbl[k] == hz) return k;
        return 15;
    endfunction

    task automatic check_rate(input int c3, input int c2, input int c0);
        int hz, lvl;
        string req;
        if (c3 < 15) begin hz = hz3(c3); lvl = 2; req = "R10"; end
        else if (c2 < 7) begin hz = hz2(c2); lvl = 1; req = "R11"; end
        else begin hz = hz0(c0); lvl = 0; req = "R11"; end
        if (hz == 0) req = "R12";
        check(req, {rate_lvl, rate_ok, 9'd0, rate_idx},
              {2'(lvl), (hz != 0), 9'd0, 4'(idx_of(hz))});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : main
        logic [15:0] pats [4] = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rdata, 16'h0000);
        check("R12", {rate_lvl, rate_ok, 9'd0, rate_idx}, {2'd0, 1'b1, 9'd0, 4'd1});
        sweep_all("R1");

        // Masks and write decode on every mapped offset.
        for (int a = 0; a < 27; a++) begin
            for (int p = 0; p < 4; p++) begin
                bus_wr(a, (a == 25) ? (pats[p] & 16'hFFFD) : pats[p]);
                bus_rd(a, req_of(a));
            end
            for (int b = 0; b < 16; b++) begin
                if (!(a == 25 && b == 1)) begin
                    bus_wr(a, 16'(1) << b);
                    bus_rd(a, req_of(a));
                end
            end
        end
        sweep_all("R2");

        // Byte halves of the test data word stay independent.
        bus_wr(6, 16'h12AB); bus_wr(7, 16'h34CD);
        bus_rd(6, "R5"); bus_rd(7, "R5");
        bus_wr(6, 16'h0011); bus_rd(7, "R5");

        // Live status merged into the test control read.
        bus_wr(4, 16'hFFFF);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            rx_avail = s[0]; tx_room = s[1];
            bus_rd(4, "R8");
        end

        // Control mirror with bit 1 clear and set.
        bus_wr(21, 16'h0001); bus_rd(21, "R7");
        bus_wr(21, 16'h0002); bus_rd(21, "R7");

        // Constant and unmapped writes leave everything intact.
        bus_wr(24, 16'hFFFF); bus_wr(26, 16'h0000);
        bus_wr(27, 16'hFFFF); bus_wr(63, 16'h1234);
        sweep_all("R4");

        // Software reset and plain system config write.
        bus_wr(25, 16'hFFFF);
        sweep_all("R3");
        bus_wr(25, 16'h0001); bus_rd(25, "R3"); bus_rd(15, "R3");

        // Rate priority, exhaustively.
        for (int c3 = 0; c3 < 16; c3++)
            for (int c2 = 0; c2 < 8; c2++)
                for (int c0 = 0; c0 < 4; c0++) begin
                    bus_wr(23, 16'(c3 << 9) | 16'h8103);
                    bus_wr(22, 16'(c2) | 16'h0028);
                    bus_wr(20, 16'(c0 << 6) | 16'h0409);
                    check_rate(c3, c2, c0);
                end
        report();
    end
endmodule